// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the command engine of a byte-level I2C master. Software programs a transmit byte, a small byte pool and a pair of pool counts, then writes one command word. That word may ask for any mix of a START with address, a payload transmit, a receive (with or without a final NACK) and a STOP. The engine always runs whichever steps are requested in the same fixed order. Each step is carried out as one or more requests on an abstract byte-level bus port, where an external bit engine performs the transfer and answers with an acknowledge pulse, an ACK/NAK result and, for reads, the received byte.

While it runs, the engine keeps a 4-bit transfer state that software can read, and it raises event flags for a downstream interrupt block. Those flags are cleared by writing ones. A receive is held back while the receive-done flag is still set, and it starts by itself as soon as software clears that flag.

Register map (word addresses): 0 control, 1 command, 2 event flags, 3 byte buffer, 4 pool counts, 16+i pool byte i (i below POOL_DEPTH, which must be a power of two of at most 16). Command bits: [0] START, [1] transmit, [2] receive, [3] receive-last, [4] STOP, [5] transmit from pool, [6] receive into pool. On read, bit [16] is the live bus-busy input and bits [23:20] are the transfer state. Event flag bits: [0] ACK, [1] NAK, [2] receive done, [3] normal stop, [4] abnormal stop. Byte buffer: [7:0] transmit byte, [15:8] last received byte (read only). Pool counts: [7:0] transmit count, [15:8] receive count.

Top module: `i2cm_cmd_engine`

## Requirements
- R1: A command write loads only bits [15:0]. Reading the command word returns the bus_busy input in bit 16 and the transfer state in bits [23:20], and writing bits [31:16] changes neither of them.
- R2: A command write is ignored while both control bits [1:0] are zero, and also while seq_active is high. In that case no bus request is made and the command bits read back unchanged.
- R3: Requested steps run in the order START, transmit, receive, STOP, and each request bit clears itself when its step finishes. bus_op codes: 1 START, 2 SEND, 3 RECV, 4 NACK, 5 END.
- R4: START puts the address byte on bus_wbyte. This is pool byte 0 in pool-transmit mode and the byte-buffer transmit byte otherwise. A NAK answer sets flag bit 1 and an ACK answer sets flag bit 0.
- R5: START runs in state RESTART (3) when the state was ACTIVE (1), and in state START (2) otherwise. The state is ACTIVE after the step.
- R6: After START, the transmit request is dropped in byte mode or when the pool transmit count is 1. Otherwise transmission begins at pool index 1.
- R7: Transmit sends bytes in state TXD (4) in index order. The first NAK sets flag bit 1, issues END and stops the step. If every byte is acknowledged, flag bit 0 is set. Pool-transmit bit [5] clears when the transmit step ends and stays set if that step never runs.
- R8: Receive runs in state RXD (5). In byte mode it reads one byte into buffer bits [15:8]. In pool mode it reads the receive count of bytes into pool 0 upward. It then sets flag bit 2, issues NACK when receive-last is set, clears bits [2], [3] and [6], and ends in ACTIVE.
- R9: A receive is not started while flag bit 2 is set. When software clears flag bit 2 while a receive is pending and the engine is idle, that receive starts at once.
- R10: STOP while the state is not ACTIVE sets flag bit 4 and makes no bus request. Otherwise it issues END in state STOP (6) and sets flag bit 3. In both cases the state becomes IDLE (0).
- R11: In pool-receive mode, the number of bytes received is written back to pool-count bits [15:8].
- R12: After reset the state is IDLE (0) and the command, flags and counts read zero. The state never takes a value above 6.
- R13: evt_flags equals the flag register. Writing ones to flag bits clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register write word address |
| reg_wdata | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| bus_busy | input | 1 | Live bus-busy indication from the bus |
| bus_req | output | 1 | Bus operation request, held until bus_ack |
| bus_op | output | 3 | Requested bus operation code |
| bus_wbyte | output | 8 | Address or data byte for START/SEND |
| bus_ack | input | 1 | One-cycle completion pulse from the bus |
| bus_nak | input | 1 | NAK result, valid with bus_ack |
| bus_rbyte | input | 8 | Received byte, valid with bus_ack |
| xfer_state | output | 4 | Transfer state |
| seq_active | output | 1 | Command sequence in progress |
| evt_flags | output | 5 | Event flags toward the interrupt block |

## Verification
The bench models the step order with its own functions. It compares every bus request, including its byte and the state shown during that request, against that model. A design that ran steps out of order, or kept the transmit after a lone address, would show extra SEND requests. One that reused index 0 after START would resend the address. The bench places a NAK on a chosen request, so a design that kept sending after a NAK, or forgot the END, produces a wrong request trail. Further directed cases cover a repeated START from ACTIVE (state 3 and not 2), a STOP from IDLE (abnormal flag and no END), a pool-transmit bit that must survive when its step is skipped, and a receive held by an uncleared done flag that must start on the clearing write and not earlier.

// File: rtl/i2cm_cmd_engine.sv
module i2cm_cmd_engine #(
  parameter int POOL_DEPTH = 8,
  parameter int ADDR_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              bus_busy,
  output logic              bus_req,
  output logic [2:0]        bus_op,
  output logic [7:0]        bus_wbyte,
  input  logic              bus_ack,
  input  logic              bus_nak,
  input  logic [7:0]        bus_rbyte,
  output logic [3:0]        xfer_state,
  output logic              seq_active,
  output logic [4:0]        evt_flags
);

  localparam int PIDX_W = (POOL_DEPTH > 1) ? $clog2(POOL_DEPTH) : 1;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_BYTE = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(4);

  localparam int B_START = 0, B_TX = 1, B_RX = 2, B_LAST = 3, B_STOP = 4, B_TXP = 5, B_RXP = 6;
  localparam int F_ACK = 0, F_NAK = 1, F_RXD = 2, F_STOP = 3, F_ABN = 4;

  localparam logic [2:0] OP_START = 3'd1, OP_SEND = 3'd2, OP_RECV = 3'd3,
                         OP_NACK  = 3'd4, OP_END  = 3'd5;

  localparam logic [3:0] ST_IDLE = 4'd0, ST_ACTIVE = 4'd1, ST_START = 4'd2,
                         ST_RESTART = 4'd3, ST_TXD = 4'd4, ST_RXD = 4'd5, ST_STOP = 4'd6;

  typedef enum logic [3:0] {
    P_IDLE, P_EVAL, P_START, P_TXSEL, P_TX, P_TXEND,
    P_RXSEL, P_RX, P_RXNACK, P_STOP, P_STOPEND
  } phase_t;

  phase_t      phase;
  logic [1:0]  ctrl_en;
  logic [6:0]  cmd_q;
  logic [4:0]  flags, flag_set, flag_clr;
  logic [3:0]  xst;
  logic [7:0]  byte_tx, byte_rx, tx_cnt, rx_cnt, idx;
  logic [7:0]  pool [POOL_DEPTH];

  wire enabled  = |ctrl_en;
  wire wr_cmd   = reg_wr && reg_addr == A_CMD;
  wire wr_flag  = reg_wr && reg_addr == A_FLAG;
  wire pool_wr  = reg_wr && reg_addr[ADDR_W-1];
  wire rx_pend  = cmd_q[B_RX] | cmd_q[B_LAST];
  wire cmd_take = wr_cmd && enabled && phase == P_IDLE;
  wire rx_kick  = wr_flag && reg_wdata[F_RXD] && flags[F_RXD] && rx_pend && phase == P_IDLE;

  wire [7:0] tx_limit  = cmd_q[B_TXP] ? tx_cnt : 8'd1;
  wire [7:0] rx_limit  = cmd_q[B_RXP] ? rx_cnt : 8'd1;
  wire [7:0] addr_byte = cmd_q[B_TXP] ? pool[0] : byte_tx;
  wire [7:0] data_byte = cmd_q[B_TXP] ? pool[idx[PIDX_W-1:0]] : byte_tx;

  wire unused_bits = ^{reg_wdata, reg_addr, rd_addr};

  assign bus_req    = phase inside {P_START, P_TX, P_TXEND, P_RX, P_RXNACK, P_STOPEND};
  assign bus_wbyte  = (phase == P_START) ? addr_byte : (phase == P_TX) ? data_byte : 8'd0;
  assign xfer_state = xst;
  assign seq_active = phase != P_IDLE;
  assign evt_flags  = flags;
  assign flag_clr   = wr_flag ? reg_wdata[4:0] : 5'd0;

  always_comb begin
    case (phase)
      P_START:           bus_op = OP_START;
      P_TX:              bus_op = OP_SEND;
      P_RX:              bus_op = OP_RECV;
      P_RXNACK:          bus_op = OP_NACK;
      P_TXEND, P_STOPEND: bus_op = OP_END;
      default:           bus_op = 3'd0;
    endcase
  end

  always_comb begin
    flag_set = '0;
    case (phase)
      P_START:   if (bus_ack) flag_set[bus_nak ? F_NAK : F_ACK] = 1'b1;
      P_TX:      if (bus_ack && bus_nak) flag_set[F_NAK] = 1'b1;
      P_TXSEL:   if (idx >= tx_limit) flag_set[F_ACK] = 1'b1;
      P_RXSEL:   if (idx >= rx_limit) flag_set[F_RXD] = 1'b1;
      P_STOP:    if (xst != ST_ACTIVE) flag_set[F_ABN] = 1'b1;
      P_STOPEND: if (bus_ack) flag_set[F_STOP] = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~flag_clr) | flag_set;
  end

  always_ff @(posedge clk) begin
    if (phase == P_RX && bus_ack && cmd_q[B_RXP])
      pool[idx[PIDX_W-1:0]] <= bus_rbyte;
    else if (pool_wr)
      pool[reg_addr[PIDX_W-1:0]] <= reg_wdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= P_IDLE;
      ctrl_en <= '0;
      cmd_q   <= '0;
      xst     <= ST_IDLE;
      byte_tx <= '0;
      byte_rx <= '0;
      tx_cnt  <= '0;
      rx_cnt  <= '0;
      idx     <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) ctrl_en <= reg_wdata[1:0];
      if (reg_wr && reg_addr == A_BYTE && phase == P_IDLE) byte_tx <= reg_wdata[7:0];
      if (reg_wr && reg_addr == A_CNT && phase == P_IDLE) begin
        tx_cnt <= reg_wdata[7:0];
        rx_cnt <= reg_wdata[15:8];
      end
      case (phase)
        P_IDLE: begin
          if (cmd_take) begin
            cmd_q <= reg_wdata[6:0];
            idx   <= '0;
            phase <= P_EVAL;
          end else if (rx_kick) begin
            phase <= P_EVAL;
          end
        end
        P_EVAL: begin
          if (cmd_q[B_START]) begin
            xst   <= (xst == ST_ACTIVE) ? ST_RESTART : ST_START;
            phase <= P_START;
          end else if (cmd_q[B_TX]) begin
            xst   <= ST_TXD;
            phase <= P_TXSEL;
          end else if (rx_pend && !flags[F_RXD]) begin
            xst   <= ST_RXD;
            idx   <= '0;
            phase <= P_RXSEL;
          end else if (cmd_q[B_STOP]) begin
            phase <= P_STOP;
          end else begin
            phase <= P_IDLE;
          end
        end
        P_START: if (bus_ack) begin
          cmd_q[B_START] <= 1'b0;
          xst <= ST_ACTIVE;
          if (cmd_q[B_TXP] && tx_cnt != 8'd1) idx <= 8'd1;
          else cmd_q[B_TX] <= 1'b0;
          phase <= P_EVAL;
        end
        P_TXSEL: begin
          if (idx < tx_limit) begin
            phase <= P_TX;
          end else begin
            cmd_q[B_TX]  <= 1'b0;
            cmd_q[B_TXP] <= 1'b0;
            xst   <= ST_ACTIVE;
            phase <= P_EVAL;
          end
        end
        P_TX: if (bus_ack) begin
          if (bus_nak) begin
            phase <= P_TXEND;
          end else begin
            idx   <= idx + 8'd1;
            phase <= P_TXSEL;
          end
        end
        P_TXEND: if (bus_ack) begin
          cmd_q[B_TX]  <= 1'b0;
          cmd_q[B_TXP] <= 1'b0;
          xst   <= ST_ACTIVE;
          phase <= P_EVAL;
        end
        P_RXSEL: begin
          if (idx < rx_limit) begin
            phase <= P_RX;
          end else begin
            if (cmd_q[B_RXP]) rx_cnt <= idx;
            cmd_q[B_RXP] <= 1'b0;
            if (cmd_q[B_LAST]) begin
              phase <= P_RXNACK;
            end else begin
              cmd_q[B_RX] <= 1'b0;
              xst   <= ST_ACTIVE;
              phase <= P_EVAL;
            end
          end
        end
        P_RX: if (bus_ack) begin
          if (!cmd_q[B_RXP]) byte_rx <= bus_rbyte;
          idx   <= idx + 8'd1;
          phase <= P_RXSEL;
        end
        P_RXNACK: if (bus_ack) begin
          cmd_q[B_RX]   <= 1'b0;
          cmd_q[B_LAST] <= 1'b0;
          xst   <= ST_ACTIVE;
          phase <= P_EVAL;
        end
        P_STOP: begin
          if (xst == ST_ACTIVE) begin
            xst   <= ST_STOP;
            phase <= P_STOPEND;
          end else begin
            cmd_q[B_STOP] <= 1'b0;
            xst   <= ST_IDLE;
            phase <= P_EVAL;
          end
        end
        P_STOPEND: if (bus_ack) begin
          cmd_q[B_STOP] <= 1'b0;
          xst   <= ST_IDLE;
          phase <= P_EVAL;
        end
        default: phase <= P_IDLE;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {30'd0, ctrl_en};
      A_CMD:   rd_data = {8'd0, xst, 3'd0, bus_busy, 9'd0, cmd_q};
      A_FLAG:  rd_data = {27'd0, flags};
      A_BYTE:  rd_data = {16'd0, byte_rx, byte_tx};
      A_CNT:   rd_data = {16'd0, rx_cnt, tx_cnt};
      default: rd_data = rd_addr[ADDR_W-1] ? {24'd0, pool[rd_addr[PIDX_W-1:0]]} : 32'd0;
    endcase
  end

  // R2
  cmd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !enabled && phase == P_IDLE) |=> $stable(cmd_q));

  // R5
  start_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_op == OP_START) |-> (xst == ST_START || xst == ST_RESTART));

  // R7
  tx_nak_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_op == OP_SEND && bus_ack && bus_nak) |=> (bus_req && bus_op == OP_END));

  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_op == OP_RECV) |-> !flags[F_RXD]);

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[F_ABN]) |-> (xst == ST_IDLE && !bus_req));

  // R12
  state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xst <= ST_STOP);

endmodule

// File: tb/sim_i2cm_cmd_engine.sv
module sim_i2cm_cmd_engine;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        bus_busy = 1'b0;
  logic        bus_req;
  logic [2:0]  bus_op;
  logic [7:0]  bus_wbyte;
  logic        bus_ack = 1'b0;
  logic        bus_nak = 1'b0;
  logic [7:0]  bus_rbyte = '0;
  logic [3:0]  xfer_state;
  logic        seq_active;
  logic [4:0]  evt_flags;

  i2cm_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .bus_busy(bus_busy), .bus_req(bus_req), .bus_op(bus_op),
    .bus_wbyte(bus_wbyte), .bus_ack(bus_ack), .bus_nak(bus_nak),
    .bus_rbyte(bus_rbyte), .xfer_state(xfer_state),
    .seq_active(seq_active), .evt_flags(evt_flags)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int nak_at = 99;
  int n_log = 0, n_exp = 0;
  bit pend = 0;
  int dly = 0;
  logic [2:0] lg_op [64];
  logic [7:0] lg_dat [64];
  logic [3:0] lg_st [64];
  logic [2:0] e_op [64];
  logic [7:0] e_dat [64];
  logic [3:0] e_st [64];
  logic [7:0] m_pool [8];
  logic [7:0] m_brx = 0, m_rxcnt = 0;
  logic [3:0] m_state = 0;
  logic [4:0] m_flags = 0;
  logic [6:0] m_cmd = 0;

  // bus responder: random latency, NAK on the chosen request index
  always @(negedge clk) begin
    if (bus_ack) bus_ack = 1'b0;
    else if (bus_req) begin
      if (!pend) begin
        if (n_log < 64) begin
          lg_op[n_log] = bus_op; lg_dat[n_log] = bus_wbyte; lg_st[n_log] = xfer_state;
        end
        n_log++;
        pend = 1;
        dly = $urandom % 3;
      end
      if (dly == 0) begin
        bus_ack = 1'b1;
        bus_nak = ((n_log - 1) == nak_at);
        bus_rbyte = 8'h5A ^ 8'(n_log - 1);
        pend = 0;
      end else dly--;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic wait_idle();
    while (seq_active) @(negedge clk);
  endtask

  task automatic emit(input logic [2:0] op, input logic [7:0] d, input logic [3:0] st, output bit nk);
    e_op[n_exp] = op; e_dat[n_exp] = d; e_st[n_exp] = st;
    nk = (n_exp == nak_at);
    n_exp++;
  endtask

  // expected bus trail and final register values for one command word
  task automatic model_cmd(input logic [6:0] c, input logic [7:0] btx, input logic [7:0] tcnt, input logic [7:0] rcnt);
    bit nk, dummy;
    int idx = 0, lim;
    n_exp = 0;
    m_cmd = c;
    if (c[0]) begin
      emit(3'd1, c[5] ? m_pool[0] : btx, (m_state == 4'd1) ? 4'd3 : 4'd2, nk);
      m_flags |= nk ? 5'd2 : 5'd1;
      m_state = 4'd1;
      m_cmd[0] = 1'b0;
      if (c[5] && tcnt != 8'd1) idx = 1; else m_cmd[1] = 1'b0;
    end
    if (m_cmd[1]) begin
      lim = c[5] ? int'(tcnt) : 1;
      nk = 0;
      for (int i = idx; i < lim && !nk; i++) emit(3'd2, c[5] ? m_pool[i[2:0]] : btx, 4'd4, nk);
      if (nk) begin m_flags |= 5'd2; emit(3'd5, 8'd0, 4'd4, dummy); end
      else m_flags |= 5'd1;
      m_cmd[1] = 1'b0; m_cmd[5] = 1'b0; m_state = 4'd1;
    end
    if ((m_cmd[2] | m_cmd[3]) && !m_flags[2]) begin
      lim = c[6] ? int'(rcnt) : 1;
      for (int i = 0; i < lim; i++) begin
        logic [7:0] rb;
        rb = 8'h5A ^ 8'(n_exp);
        emit(3'd3, 8'd0, 4'd5, dummy);
        if (c[6]) m_pool[i[2:0]] = rb; else m_brx = rb;
      end
      m_flags |= 5'd4;
      if (c[6]) m_rxcnt = 8'(lim);
      m_cmd[6] = 1'b0;
      if (m_cmd[3]) emit(3'd4, 8'd0, 4'd5, dummy);
      m_cmd[2] = 1'b0; m_cmd[3] = 1'b0; m_state = 4'd1;
    end
    if (m_cmd[4]) begin
      if (m_state == 4'd1) begin emit(3'd5, 8'd0, 4'd6, dummy); m_flags |= 5'd8; end
      else m_flags |= 5'd16;
      m_state = 4'd0;
      m_cmd[4] = 1'b0;
    end
  endtask

  task automatic compare_all(input string tag);
    logic [31:0] d;
    chk({tag, " R3 request count"}, n_log, n_exp);
    for (int i = 0; i < n_exp && i < n_log; i++) begin
      chk({tag, " R3 op"}, 32'(lg_op[i]), 32'(e_op[i]));
      chk({tag, " R4 byte"}, 32'(lg_dat[i]), 32'(e_dat[i]));
      chk({tag, " R5 state during request"}, 32'(lg_st[i]), 32'(e_st[i]));
    end
    rd(5'd2, d);  chk({tag, " R13 flags"}, d, 32'(m_flags));
    chk({tag, " R13 evt_flags"}, 32'(evt_flags), 32'(m_flags));
    rd(5'd1, d);
    chk({tag, " R7 command bits"}, 32'(d[6:0]), 32'(m_cmd));
    chk({tag, " R10 state"}, 32'(d[23:20]), 32'(m_state));
    rd(5'd3, d);  chk({tag, " R8 received byte"}, 32'(d[15:8]), 32'(m_brx));
    rd(5'd4, d);  chk({tag, " R11 receive count"}, 32'(d[15:8]), 32'(m_rxcnt));
    for (int i = 0; i < 8; i++) begin
      rd(5'(16 + i), d);
      chk({tag, " R8 pool"}, 32'(d[7:0]), 32'(m_pool[i]));
    end
  endtask

  task automatic run_cmd(input string tag, input logic [6:0] c, input logic [7:0] btx,
                         input logic [7:0] tcnt, input logic [7:0] rcnt, input int nk_at);
    wr(5'd3, 32'(btx));
    wr(5'd4, {16'd0, rcnt, tcnt});
    m_rxcnt = rcnt;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v;
      v = 8'($urandom);
      wr(5'(16 + i), 32'(v));
      m_pool[i] = v;
    end
    wr(5'd2, 32'h1F);
    m_flags = 0;
    n_log = 0;
    nak_at = nk_at;
    model_cmd(c, btx, tcnt, rcnt);
    wr(5'd1, 32'(c));
    wait_idle();
    compare_all(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R3 act=hung exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset values
    rd(5'd1, d); chk("R12 reset command", d, 32'd0);
    rd(5'd2, d); chk("R12 reset flags", d, 32'd0);
    rd(5'd4, d); chk("R12 reset counts", d, 32'd0);
    chk("R12 reset state", 32'(xfer_state), 32'd0);

    // R2 disabled bus ignores commands
    n_log = 0;
    wr(5'd1, 32'h11);
    repeat (4) @(negedge clk);
    chk("R2 no request when disabled", n_log, 0);
    rd(5'd1, d); chk("R2 command bits unchanged", 32'(d[6:0]), 32'd0);
    chk("R2 not active", 32'(seq_active), 32'd0);

    wr(5'd0, 32'h1);

    // R1 busy bit and upper bits
    bus_busy = 1'b1;
    rd(5'd1, d); chk("R1 busy bit high", 32'(d[16]), 32'd1);
    bus_busy = 1'b0;
    rd(5'd1, d); chk("R1 busy bit low", 32'(d[16]), 32'd0);
    wr(5'd1, 32'hFFFF_0000);
    wait_idle();
    rd(5'd1, d); chk("R1 upper write leaves state", 32'(d[23:16]), 32'd0);

    // R10 stop from idle
    run_cmd("stop-idle R10", 7'h10, 8'h00, 8'd1, 8'd0, 99);
    // R6 byte mode: start drops transmit
    run_cmd("byte start R6", 7'h13, 8'hA4, 8'd1, 8'd0, 99);
    // R5 start then repeated start
    run_cmd("first start R5", 7'h01, 8'h31, 8'd1, 8'd0, 99);
    run_cmd("restart R5", 7'h01, 8'h32, 8'd1, 8'd0, 99);
    run_cmd("stop after restart R10", 7'h10, 8'h00, 8'd1, 8'd0, 99);
    // R6 R7 pool count one: transmit dropped, pool bit kept
    run_cmd("pool count one R7", 7'h33, 8'h00, 8'd1, 8'd0, 99);
    // R7 NAK in the middle of a pool transmit
    run_cmd("pool nak R7", 7'h33, 8'h00, 8'd4, 8'd0, 2);
    // R4 address NAK
    run_cmd("address nak R4", 7'h13, 8'h77, 8'd1, 8'd0, 0);
    // R8 R11 pool receive with final NACK
    run_cmd("pool rx last R8", 7'h5D, 8'h50, 8'd1, 8'd3, 99);

    // R9 receive held while done flag is set
    run_cmd("byte rx R9", 7'h04, 8'h00, 8'd1, 8'd0, 99);
    n_log = 0;
    nak_at = 99;
    wr(5'd1, 32'h04);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R9 held receive makes no request", n_log, 0);
    rd(5'd1, d); chk("R9 receive bit pending", 32'(d[2]), 32'd1);
    wr(5'd2, 32'h04);
    wait_idle();
    chk("R9 released receive request count", n_log, 1);
    chk("R9 released receive op", 32'(lg_op[0]), 32'd3);
    chk("R9 released receive state", 32'(lg_st[0]), 32'd5);
    rd(5'd3, d); chk("R9 received byte", 32'(d[15:8]), 32'h5A);
    m_brx = 8'h5A;
    rd(5'd2, d); chk("R9 done flag set again", d, 32'h04);
    rd(5'd1, d); chk("R9 receive bit cleared", 32'(d[2]), 32'd0);

    // mixed random commands
    for (int it = 0; it < 60; it++) begin
      run_cmd("random R3", 7'($urandom), 8'($urandom), 8'(1 + $urandom % 4),
              8'($urandom % 5), int'($urandom % 8));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule